// File: doc/BRIEF.md
# Streaming Column Pooling Unit

This unit downsamples the finished output of a convolution stage. Pixels arrive one per valid beat, 8 bits each, in column order: every row of column 0 from the top down, then every row of column 1, and so on. A frame has `ROWS` rows and `COLS` columns. Frames follow each other with no gap or marker. For every pixel that completes a pooling window, the unit returns either the largest value in that `WIN`×`WIN` window or its rounded mean.

The pixel that completes a window is never stored and read back. It goes straight into the combining logic. The other `WIN*WIN-1` window members come from a small circular buffer that holds the last `WIN` columns. Windows advance by `STEP` in both directions. Beats that do not complete a stride-aligned window give no output, and neither do incomplete windows at the bottom and right edges. The caller may drop `in_valid` at any time.

Top module: `col_pool_stream`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0. The next accepted beat is taken as row 0, column 0 of a new frame.
- R2: A cycle with `in_valid` low does not advance the pixel position, does not change any stored pixel, and gives `out_valid` 0 on the following cycle. The values on `in_data` and `avg_mode` during such a cycle have no effect.
- R3: `out_valid` is 1 on exactly the cycle after an accepted beat at row r, column c, where r ≥ WIN-1, c ≥ WIN-1, and both (r-WIN+1) and (c-WIN+1) are multiples of STEP. The window covers rows r-WIN+1..r and columns c-WIN+1..c.
- R4: When `avg_mode` is 0 on the completing beat, `out_data` is the largest of the window's unsigned values.
- R5: When `avg_mode` is 1 and WIN=2, `out_data` is (sum+2)>>2, where sum is the total of the four values.
- R6: When `avg_mode` is 1 and WIN=3, `out_data` is the nine-value sum divided by 9 and rounded to the nearest integer, which equals floor((sum+4)/9).
- R7: The mode is sampled only on the completing beat. It may change from beat to beat without affecting any other window.
- R8: Beats in stride phases between outputs, and windows that would run past the last row or column, give no output. Each frame gives exactly (floor((ROWS-WIN)/STEP)+1) × (floor((COLS-WIN)/STEP)+1) outputs.
- R9: After the beat at the last row of the last column, the next beat is row 0, column 0 of the following frame. Back-to-back frames pool independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_data` as the next pixel |
| in_data | input | DW | Convolution result, unsigned |
| avg_mode | input | 1 | 1 = mean of window, 0 = maximum |
| out_valid | output | 1 | A pooled value is present |
| out_data | output | DW | Pooled value |

## Verification
The bench builds two instances from the same input stream. One has WIN=2, STEP=2 on a 7×7 frame. The other has WIN=3, STEP=2 on an 8×8 frame. Both sizes leave a row and a column over at the far edges, so edge discard is tested in both. The 8×8 instance uses counters that wrap at a power of two, and the 7×7 instance uses counters that do not. The two instances also cover both averaging datapaths: the shift for WIN=2 and the reciprocal multiply for WIN=3. The stream includes saturated and all-zero frames, random stalls, a mode that changes on every beat, and a reset in the middle of a frame.

// File: rtl/cpool_pkg.sv
`timescale 1ns/1ps
package cpool_pkg;
    typedef enum logic {
        POOL_MAX = 1'b0,
        POOL_AVG = 1'b1
    } pool_mode_e;

    // fraction bits of the fixed-point reciprocal used for non-power-of-two averages
    localparam int RECIP_FRAC = 16;
endpackage

// File: rtl/cpool_pos.sv
`timescale 1ns/1ps
// Position tracker: follows row/column of the incoming beat and decides
// whether that beat closes a stride-aligned window.
module cpool_pos #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int WIN  = 2,
    parameter int STEP = 2,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS),
    localparam int SW  = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat_i,
    output logic [RW-1:0] row_o,
    output logic [CW-1:0] col_o,
    output logic [SW-1:0] slot_o,
    output logic          fire_o
);
    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic [SW-1:0] slot;
    } pos_t;

    pos_t st_d, st_q;
    logic row_ok, col_ok;

    always_comb begin
        int r_i;
        int c_i;
        st_d = st_q;
        r_i  = int'(st_q.row);
        c_i  = int'(st_q.col);
        row_ok = (r_i >= WIN - 1) && (((r_i - (WIN - 1)) % STEP) == 0);
        col_ok = (c_i >= WIN - 1) && (((c_i - (WIN - 1)) % STEP) == 0);
        if (beat_i) begin
            if (st_q.row == RW'(ROWS - 1)) begin
                st_d.row = '0;
                if (st_q.col == CW'(COLS - 1)) begin
                    st_d.col  = '0;
                    st_d.slot = '0;
                end else begin
                    st_d.col  = st_q.col + 1'b1;
                    st_d.slot = (st_q.slot == SW'(WIN - 1)) ? '0 : st_q.slot + 1'b1;
                end
            end else begin
                st_d.row = st_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_o  = st_q.row;
    assign col_o  = st_q.col;
    assign slot_o = st_q.slot;
    assign fire_o = beat_i && row_ok && col_ok;

    // R2: an idle cycle leaves the position untouched
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_i |=> $stable(st_q))
        else $error("position moved without a beat");

    // R9: the position stays within the frame and wraps there
    p_pos_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(st_q.row) < ROWS) && (int'(st_q.col) < COLS) && (int'(st_q.slot) < WIN))
        else $error("position outside frame");
endmodule

// File: rtl/cpool_win.sv
`timescale 1ns/1ps
// Circular column store (WIN columns deep) plus window gather.
// Window element index = dc*WIN + dr, dc=0 oldest column, dr=0 top row.
module cpool_win #(
    parameter int ROWS = 8,
    parameter int WIN  = 2,
    parameter int DW   = 8,
    localparam int RW  = $clog2(ROWS),
    localparam int SW  = $clog2(WIN),
    localparam int NEL = WIN * WIN
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [RW-1:0]           row_i,
    input  logic [SW-1:0]           slot_i,
    input  logic [DW-1:0]           data_i,
    output logic [NEL-1:0][DW-1:0]  win_o
);
    logic [DW-1:0] mem_d [WIN][ROWS];
    logic [DW-1:0] mem_q [WIN][ROWS];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[slot_i][row_i] = data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < WIN; s++)
                for (int r = 0; r < ROWS; r++)
                    mem_q[s][r] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // The newest element bypasses the store; the rest are read from it.
    always_comb begin
        int r_idx;
        int s_idx;
        for (int dc = 0; dc < WIN; dc++) begin
            for (int dr = 0; dr < WIN; dr++) begin
                r_idx = int'(row_i) - (WIN - 1) + dr;
                s_idx = (int'(slot_i) + dc + 1) % WIN;
                if (dc == WIN - 1 && dr == WIN - 1)
                    win_o[dc*WIN + dr] = data_i;
                else if (r_idx >= 0 && r_idx < ROWS)
                    win_o[dc*WIN + dr] = mem_q[s_idx[SW-1:0]][r_idx[RW-1:0]];
                else
                    win_o[dc*WIN + dr] = '0;
            end
        end
    end
endmodule

// File: rtl/cpool_reduce.sv
`timescale 1ns/1ps
// Window combiner: maximum or rounded mean; the mean datapath is chosen by WIN.
module cpool_reduce
    import cpool_pkg::*;
#(
    parameter int WIN  = 2,
    parameter int DW   = 8,
    localparam int NEL  = WIN * WIN,
    localparam int SUMW = DW + $clog2(NEL),
    localparam int RECIP = ((1 << RECIP_FRAC) + NEL / 2) / NEL
) (
    input  logic [NEL-1:0][DW-1:0] win_i,
    input  logic                   avg_i,
    output logic [DW-1:0]          res_o
);
    logic [SUMW-1:0] sum_v;
    logic [DW-1:0]   max_v;
    logic [DW-1:0]   avg_v;
    pool_mode_e      mode;

    always_comb begin
        sum_v = '0;
        max_v = '0;
        for (int i = 0; i < NEL; i++) begin
            sum_v = sum_v + SUMW'(win_i[i]);
            if (win_i[i] > max_v) max_v = win_i[i];
        end
    end

    generate
        if (WIN == 2) begin : g_avg_shift
            always_comb avg_v = DW'((sum_v + SUMW'(2)) >> 2);
        end else if (WIN == 3) begin : g_avg_recip
            logic [SUMW+RECIP_FRAC-1:0] prod;
            always_comb begin
                prod  = (SUMW+RECIP_FRAC)'(sum_v) * (SUMW+RECIP_FRAC)'(RECIP)
                      + (SUMW+RECIP_FRAC)'(1 << (RECIP_FRAC - 1));
                avg_v = prod[RECIP_FRAC +: DW];
            end
        end else begin : g_avg_div
            always_comb avg_v = DW'((sum_v + SUMW'(NEL / 2)) / SUMW'(NEL));
        end
    endgenerate

    always_comb begin
        mode  = pool_mode_e'(avg_i);
        res_o = (mode == POOL_AVG) ? avg_v : max_v;
    end

    // R5: the mean path never exceeds the independently computed maximum
    always_comb begin
        p_avg_bound_r5: assert (avg_v <= max_v)
            else $error("mean above window maximum");
    end
endmodule

// File: rtl/col_pool_stream.sv
`timescale 1ns/1ps
module col_pool_stream #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int WIN  = 2,
    parameter int STEP = 2,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          avg_mode,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    localparam int RW  = $clog2(ROWS);
    localparam int CW  = $clog2(COLS);
    localparam int SW  = $clog2(WIN);
    localparam int NEL = WIN * WIN;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } out_t;

    logic [RW-1:0]          row;
    logic [CW-1:0]          col;
    logic [SW-1:0]          slot;
    logic                   fire;
    logic [NEL-1:0][DW-1:0] window;
    logic [DW-1:0]          pooled;
    out_t                   out_d, out_q;

    cpool_pos #(.ROWS(ROWS), .COLS(COLS), .WIN(WIN), .STEP(STEP)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat_i (in_valid),
        .row_o  (row),
        .col_o  (col),
        .slot_o (slot),
        .fire_o (fire)
    );

    cpool_win #(.ROWS(ROWS), .WIN(WIN), .DW(DW)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (in_valid),
        .row_i  (row),
        .slot_i (slot),
        .data_i (in_data),
        .win_o  (window)
    );

    cpool_reduce #(.WIN(WIN), .DW(DW)) u_red (
        .win_i (window),
        .avg_i (avg_mode),
        .res_o (pooled)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = fire;
        if (fire) out_d.data = pooled;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign out_data  = out_q.data;

    // R3: a pooled value only ever follows an accepted beat
    p_out_after_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid))
        else $error("output without a completing beat");

    // R8: beats off the stride grid in the column direction stay silent
    p_col_phase_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((int'(col) < WIN - 1) || (((int'(col) - (WIN - 1)) % STEP) != 0)))
        |=> !out_valid)
        else $error("output on an idle column phase");
endmodule

// File: tb/col_pool_stream_tb.sv
`timescale 1ns/1ps
module col_pool_stream_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       avg_mode = 1'b0;
    logic       ov2, ov3;
    logic [7:0] od2, od3;

    always #2.5 clk = ~clk;

    col_pool_stream #(.ROWS(7), .COLS(7), .WIN(2), .STEP(2), .DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .avg_mode(avg_mode), .out_valid(ov2), .out_data(od2));

    col_pool_stream #(.ROWS(8), .COLS(8), .WIN(3), .STEP(2), .DW(8)) u_dut_k3 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .avg_mode(avg_mode), .out_valid(ov3), .out_data(od3));

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int    kk [2] = '{2, 3};
    int    hh [2] = '{7, 8};
    int    ww [2] = '{7, 8};
    int    img [2][8][8];
    int    prow [2];
    int    pcol [2];
    bit    exp_v [2];
    int    exp_d [2];
    string vtag [2];
    string dtag [2];
    int    seen [2];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic observe();
        int av [2];
        int ad [2];
        av[0] = int'(ov2); ad[0] = int'(od2);
        av[1] = int'(ov3); ad[1] = int'(od3);
        for (int id = 0; id < 2; id++) begin
            chk(vtag[id], av[id], int'(exp_v[id]));
            if (exp_v[id]) chk(dtag[id], ad[id], exp_d[id]);
            if (av[id] != 0) seen[id]++;
        end
    endtask

    // behavioural reference: position, frame image and pooled value
    task automatic model(input int id, input bit v, input int d, input bit m);
        int k, r, c, sum, mx, last_r, last_c;
        bit fire;
        exp_v[id] = 1'b0;
        vtag[id]  = "R2 stall gives no output";
        if (!v) return;
        k = kk[id]; r = prow[id]; c = pcol[id];
        img[id][r][c] = d;
        last_r = k - 1 + ((hh[id] - k) / 2) * 2;
        last_c = k - 1 + ((ww[id] - k) / 2) * 2;
        fire = (r >= k - 1) && (c >= k - 1) && ((r - k + 1) % 2 == 0) && ((c - k + 1) % 2 == 0);
        if (fire) vtag[id] = "R3 window completes";
        else if (r > last_r || c > last_c) vtag[id] = "R8 partial edge window discarded";
        else vtag[id] = "R8 stride idle phase";
        if (fire) begin
            sum = 0; mx = 0;
            for (int i = r - k + 1; i <= r; i++)
                for (int j = c - k + 1; j <= c; j++) begin
                    sum += img[id][i][j];
                    if (img[id][i][j] > mx) mx = img[id][i][j];
                end
            exp_v[id] = 1'b1;
            if (!m) begin
                exp_d[id] = mx;
                dtag[id]  = "R4 max (R7 per-beat mode)";
            end else if (k == 2) begin
                exp_d[id] = (sum + 2) / 4;
                dtag[id]  = "R5 mean of 4 (R7 per-beat mode)";
            end else begin
                exp_d[id] = (sum + 4) / 9;
                dtag[id]  = "R6 mean of 9 (R7 per-beat mode)";
            end
        end
        r++;
        if (r == hh[id]) begin
            r = 0; c++;
            if (c == ww[id]) c = 0; // R9 next frame
        end
        prow[id] = r; pcol[id] = c;
    endtask

    task automatic step(input bit v, input int d, input bit m);
        @(negedge clk);
        observe();
        in_valid = v; in_data = 8'(d); avg_mode = m;
        for (int id = 0; id < 2; id++) model(id, v, d, m);
    endtask

    task automatic do_reset();
        @(negedge clk);
        observe();
        rst_n = 1'b0; in_valid = 1'b0;
        for (int id = 0; id < 2; id++) begin
            prow[id] = 0; pcol[id] = 0; exp_v[id] = 1'b0;
            vtag[id] = "R1 reset output low";
        end
        repeat (2) begin
            @(negedge clk);
            observe();
        end
        rst_n = 1'b1;
        for (int id = 0; id < 2; id++) seen[id] = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        int seg, d;
        bit m;
        for (int id = 0; id < 2; id++) begin
            prow[id] = 0; pcol[id] = 0; exp_v[id] = 0; seen[id] = 0;
            vtag[id] = "R1 reset output low"; dtag[id] = "R4";
        end
        do_reset();
        // partial frame, then reset mid-frame: R1 restart at origin
        for (int b = 0; b < 11; b++) step(1'b1, $urandom_range(0, 255), 1'b0);
        do_reset();
        for (int b = 0; b < 3136; b++) begin
            seg = b / 640;
            case (seg)
                0:       begin d = $urandom_range(0, 255); m = 1'b0; end
                1:       begin d = 255;                    m = 1'b1; end
                2:       begin d = $urandom_range(0, 255); m = 1'b1; end
                3:       begin d = (b % 128 < 64) ? 0 : $urandom_range(0, 255); m = 1'($urandom_range(0, 1)); end
                default: begin d = $urandom_range(0, 255); m = 1'($urandom_range(0, 1)); end
            endcase
            if (seg >= 2 && $urandom_range(0, 3) == 0) begin
                // R2: idle cycles carry junk that must be ignored
                repeat ($urandom_range(1, 2)) step(1'b0, $urandom_range(0, 255), 1'($urandom_range(0, 1)));
            end
            step(1'b1, d, m);
        end
        step(1'b0, 0, 1'b0);
        step(1'b0, 0, 1'b0);
        // R8: 64 frames of 7x7 -> 9 each; 49 frames of 8x8 -> 9 each
        chk("R8 pooled count k2", seen[0], 576);
        chk("R8 pooled count k3", seen[1], 441);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule